// File: doc/BRIEF.md
# PHY Management Status Register File

This block is a 16-bit wide management register file for a home-networking PHY. It keeps three pieces of PHY state. The first is a 32-bit out-of-band word taken from received packets. The second is an 8-bit access identifier that software can write-protect. The third is an 8-bit count of noise events that stops at its maximum and can be cleared by software. Software reaches these through a register port with address, write data, read data and separate read and write strobes. The receive path delivers each packet's 32-bit word with a one-cycle strobe. The noise detector reports each event with a one-cycle pulse.

The out-of-band word reads as two halves, high and low. Reads of these halves have side effects. A read of the low half locks the capture, so a later packet cannot change the word before the high half is read. A read of the high half unlocks the capture and clears the receive-valid flag. A packet that arrives in the same cycle as the high-half read is not lost: it is held for one cycle and captured after the unlock.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset these addresses read as follows: 16 reads 0000h, 20, 21 and 26 read 0000h, 22 reads 00FFh, and 23 reads 0003h.
- R2: When the capture is unlocked, a packet strobe stores its 32-bit word at the next clock edge. Address 20 then returns bits 31:16 and address 21 returns bits 15:0.
- R3: A captured word that is non-zero sets the receive-valid flag, which reads as bit 0 of address 26. A captured word of zero leaves that bit at 0.
- R4: A read of address 21 locks the capture, and packets arriving afterwards leave the stored word unchanged. A packet in the same cycle as that read is also discarded.
- R5: A read of address 20 clears the receive-valid flag and unlocks the capture.
- R6: A packet in the same cycle as a read of address 20 is not stored at that edge. It is stored at the following edge, so bit 0 of address 26 is 0 for one cycle and then 1.
- R7: Address 22 keeps an 8-bit identifier in bits 7:0, written from write-data bits 7:0. Bits 15:8 read 0.
- R8: Bit 7 of address 16 is a write-protect flag that can be read and written. While it is 1, writes to address 22 have no effect.
- R9: Each noise pulse adds one to the counter, which reads in bits 15:8 of address 23.
- R10: The noise counter stays at FFh when more pulses arrive and does not wrap.
- R11: A write to address 16 with bit 6 set clears the noise counter. This clear wins over a noise pulse in the same cycle. Bit 6 always reads 0.
- R12: Bits 7:0 of address 23 can be read and written, and a write there does not change the counter in bits 15:8.
- R13: Addresses with no register read 0000h. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| pkt_vld | input | 1 | Strobe that marks a received packet word |
| pkt_word | input | 32 | Out-of-band word of the received packet |
| noise_evt | input | 1 | One-cycle pulse for each noise event |

## Verification
Two pairs of events can fall in the same cycle and are tested that way. In the first pair, a packet strobe is driven in the same cycle as a high-half read. Address 26 is then read twice: the first read must show the valid bit at 0 and the second at 1, and the new word must then read back. The second pair is a noise pulse held high during the write that clears the counter. The count read back must be 0. A packet that coincides with a low-half read is also checked: it must be dropped.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int COMM_W = 32;
    localparam int HALF_W = COMM_W / 2;
    localparam int ID_W   = 8;
    localparam int CNT_W  = 8;
    localparam int FLR_W  = 8;

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] A_COMM_HI = ADDR_W'(20);
    localparam logic [ADDR_W-1:0] A_COMM_LO = ADDR_W'(21);
    localparam logic [ADDR_W-1:0] A_ID      = ADDR_W'(22);
    localparam logic [ADDR_W-1:0] A_NOISE   = ADDR_W'(23);
    localparam logic [ADDR_W-1:0] A_EVT     = ADDR_W'(26);

    localparam int CTRL_PROT_BIT = 7;
    localparam int CTRL_NCLR_BIT = 6;
    localparam int EVT_RXV_BIT   = 0;

    localparam logic [ID_W-1:0]  ID_RST  = '1;
    localparam logic [FLR_W-1:0] FLR_RST = FLR_W'(3);

    typedef struct packed {
        logic ctrl_wr;
        logic id_wr;
        logic noise_wr;
        logic hi_rd;
        logic lo_rd;
    } acc_t;

    function automatic acc_t decode_acc(
        input logic [ADDR_W-1:0] addr,
        input logic              wr,
        input logic              rd
    );
        acc_t a;
        a.ctrl_wr  = wr && (addr == A_CTRL);
        a.id_wr    = wr && (addr == A_ID);
        a.noise_wr = wr && (addr == A_NOISE);
        a.hi_rd    = rd && (addr == A_COMM_HI);
        a.lo_rd    = rd && (addr == A_COMM_LO);
        return a;
    endfunction

endpackage

// File: rtl/phy_mgmt_capture.sv
module phy_mgmt_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pkt_vld,
    input  logic [W-1:0] pkt_word,
    input  logic         lo_rd,
    input  logic         hi_rd,
    output logic [W-1:0] word_q,
    output logic         valid_q,
    output logic         frozen_q
);
    logic         pend_vld;
    logic [W-1:0] pend_word;
    logic         take;
    logic [W-1:0] take_word;

    always_comb begin
        take_word = pkt_vld ? pkt_word : pend_word;
        take      = (pkt_vld || pend_vld) && !frozen_q && !lo_rd && !hi_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_word <= '0;
            word_q    <= '0;
            valid_q   <= 1'b0;
            frozen_q  <= 1'b0;
        end else begin
            pend_vld <= hi_rd && pkt_vld;
            if (hi_rd && pkt_vld) begin
                pend_word <= pkt_word;
            end
            if (hi_rd) begin
                frozen_q <= 1'b0;
                valid_q  <= 1'b0;
            end else if (lo_rd) begin
                frozen_q <= 1'b1;
            end else if (take) begin
                word_q  <= take_word;
                valid_q <= |take_word;
            end
        end
    end
endmodule

// File: rtl/phy_mgmt_noise_ctr.sv
module phy_mgmt_noise_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         evt,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (evt && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pkt_vld,
    input  logic [COMM_W-1:0] pkt_word,
    input  logic              noise_evt
);
    acc_t              acc;
    logic [COMM_W-1:0] comm_word;
    logic              comm_valid;
    logic              comm_frozen;
    logic              id_prot;
    logic [ID_W-1:0]   id_q;
    logic [FLR_W-1:0]  floor_q;
    logic [CNT_W-1:0]  noise_cnt;
    logic              noise_clr;

    always_comb begin
        acc       = decode_acc(reg_addr, reg_wr, reg_rd);
        noise_clr = acc.ctrl_wr && reg_wdata[CTRL_NCLR_BIT];
    end

    phy_mgmt_capture #(.W(COMM_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .pkt_vld  (pkt_vld),
        .pkt_word (pkt_word),
        .lo_rd    (acc.lo_rd),
        .hi_rd    (acc.hi_rd),
        .word_q   (comm_word),
        .valid_q  (comm_valid),
        .frozen_q (comm_frozen)
    );

    phy_mgmt_noise_ctr #(.W(CNT_W)) u_noise (
        .clk   (clk),
        .rst   (rst),
        .clr   (noise_clr),
        .evt   (noise_evt),
        .cnt_q (noise_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            id_prot <= 1'b0;
            id_q    <= ID_RST;
            floor_q <= FLR_RST;
        end else begin
            if (acc.ctrl_wr) begin
                id_prot <= reg_wdata[CTRL_PROT_BIT];
            end
            if (acc.id_wr && !id_prot) begin
                id_q <= reg_wdata[ID_W-1:0];
            end
            if (acc.noise_wr) begin
                floor_q <= reg_wdata[FLR_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:    reg_rdata[CTRL_PROT_BIT] = id_prot;
            A_COMM_HI: reg_rdata = comm_word[COMM_W-1:HALF_W];
            A_COMM_LO: reg_rdata = comm_word[HALF_W-1:0];
            A_ID:      reg_rdata[ID_W-1:0] = id_q;
            A_NOISE:   reg_rdata = {noise_cnt, floor_q};
            A_EVT:     reg_rdata[EVT_RXV_BIT] = comm_valid;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk
    import phy_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              noise_evt,
    input logic [COMM_W-1:0] comm_word,
    input logic              comm_valid,
    input logic              comm_frozen,
    input logic              id_prot,
    input logic [ID_W-1:0]   id_q,
    input logic [CNT_W-1:0]  noise_cnt,
    input logic              noise_clr
);
    // R4
    comm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (comm_frozen && !(reg_rd && reg_addr == A_COMM_HI)) |=> $stable(comm_word));

    // R5
    hi_release_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_COMM_HI) |=> (!comm_valid && !comm_frozen));

    // R8
    id_protect_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_ID && id_prot) |=> $stable(id_q));

    // R9
    noise_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (noise_evt && !noise_clr && noise_cnt != '1) |=> (noise_cnt == $past(noise_cnt) + 1'b1));

    // R10
    noise_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (noise_cnt == '1 && !noise_clr) |=> (noise_cnt == '1));

    // R11
    noise_clr_chk: assert property (@(posedge clk) disable iff (rst)
        noise_clr |=> (noise_cnt == '0));
endmodule

bind phy_mgmt_regs phy_mgmt_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .noise_evt   (noise_evt),
    .comm_word   (comm_word),
    .comm_valid  (comm_valid),
    .comm_frozen (comm_frozen),
    .id_prot     (id_prot),
    .id_q        (id_q),
    .noise_cnt   (noise_cnt),
    .noise_clr   (noise_clr)
);

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic        pkt_vld = 1'b0;
    logic [31:0] pkt_word = '0;
    logic        noise_evt = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_mgmt_regs u_phy_mgmt_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .pkt_vld(pkt_vld), .pkt_word(pkt_word), .noise_evt(noise_evt)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op_write(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic op_read(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #(CLK_PERIOD/4);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic send_pkt(input logic [31:0] w);
        pkt_vld = 1'b1; pkt_word = w;
        @(posedge clk); #1;
        pkt_vld = 1'b0;
    endtask

    task automatic test_reset();
        logic [15:0] d;
        op_read(5'd16, d); check("R1 ctrl", d, 16'h0000);
        op_read(5'd22, d); check("R1 id", d, 16'h00FF);
        op_read(5'd23, d); check("R1 noise", d, 16'h0003);
        op_read(5'd26, d); check("R1 evt", d, 16'h0000);
        op_read(5'd20, d); check("R1 hi", d, 16'h0000);
        op_read(5'd21, d); check("R1 lo", d, 16'h0000);
        op_read(5'd20, d); // unlock again after the low read
    endtask

    task automatic test_capture_lock();
        logic [15:0] d;
        send_pkt(32'hDEADBEEF);
        op_read(5'd26, d); check("R3 valid set", d, 16'h0001);
        op_read(5'd21, d); check("R2 low half", d, 16'hBEEF);
        send_pkt(32'h11112222);
        op_read(5'd21, d); check("R4 locked low", d, 16'hBEEF);
        op_read(5'd20, d); check("R4 locked high", d, 16'hDEAD);
        op_read(5'd26, d); check("R5 valid cleared", d, 16'h0000);
        send_pkt(32'h33334444);
        op_read(5'd20, d); check("R5 unlocked high", d, 16'h3333);
        // packet together with a low read is dropped
        pkt_vld = 1'b1; pkt_word = 32'h55556666;
        op_read(5'd21, d); check("R4 read before drop", d, 16'h4444);
        pkt_vld = 1'b0;
        op_read(5'd21, d); check("R4 same-cycle drop", d, 16'h4444);
        op_read(5'd20, d); check("R2 high half", d, 16'h3333);
        send_pkt(32'h0);
        op_read(5'd26, d); check("R3 zero word", d, 16'h0000);
    endtask

    task automatic test_collide();
        logic [15:0] d;
        pkt_vld = 1'b1; pkt_word = 32'hCAFEF00D;
        op_read(5'd20, d); check("R6 old high", d, 16'h0000);
        pkt_vld = 1'b0;
        op_read(5'd26, d); check("R6 valid low first", d, 16'h0000);
        op_read(5'd26, d); check("R6 valid high next", d, 16'h0001);
        op_read(5'd21, d); check("R6 low half", d, 16'hF00D);
        op_read(5'd20, d); check("R6 high half", d, 16'hCAFE);
    endtask

    task automatic test_id();
        logic [15:0] d;
        op_write(5'd22, 16'h1234);
        op_read(5'd22, d); check("R7 id write", d, 16'h0034);
        op_write(5'd16, 16'h0080);
        op_read(5'd16, d); check("R8 prot reads", d, 16'h0080);
        op_write(5'd22, 16'h00AA);
        op_read(5'd22, d); check("R8 id protected", d, 16'h0034);
        op_write(5'd16, 16'h0000);
        op_write(5'd22, 16'h00AA);
        op_read(5'd22, d); check("R8 id unprotected", d, 16'h00AA);
    endtask

    task automatic test_noise();
        logic [15:0] d;
        for (int i = 0; i < 5; i++) begin
            noise_evt = 1'b1; @(posedge clk); #1; noise_evt = 1'b0;
        end
        op_read(5'd23, d); check("R9 count 5", d, 16'h0503);
        op_write(5'd23, 16'hAB55);
        op_read(5'd23, d); check("R12 floor write", d, 16'h0555);
        noise_evt = 1'b1;
        repeat (300) @(posedge clk);
        #1; noise_evt = 1'b0;
        op_read(5'd23, d); check("R10 saturate", d, 16'hFF55);
        noise_evt = 1'b1;
        op_write(5'd16, 16'h0040);
        noise_evt = 1'b0;
        op_read(5'd23, d); check("R11 clear wins", d, 16'h0055);
        op_read(5'd16, d); check("R11 clear bit reads 0", d, 16'h0000);
    endtask

    task automatic test_unmapped();
        logic [15:0] d;
        op_write(5'd5, 16'hFFFF);
        op_read(5'd5, d); check("R13 unmapped read", d, 16'h0000);
        op_write(5'd31, 16'hFFFF);
        op_read(5'd22, d); check("R13 id untouched", d, 16'h00AA);
        op_read(5'd16, d); check("R13 ctrl untouched", d, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        test_capture_lock();
        test_collide();
        test_id();
        test_noise();
        test_unmapped();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule